// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a burst request into the column addresses a double-data-rate memory array needs. A small mode register inside the block holds the burst length, the burst order and the read latency. It is written whenever the mode-write strobe is high. A start strobe with a starting column then opens a read or write burst. Data moves on both edges of the data strobe, so the generator issues two column addresses per clock on two lanes: lane A carries the even beat and lane B the odd beat that follows it.

Fixed bursts of 2, 4 or 8 beats wrap inside the aligned block of that size, in sequential or interleaved order. A full-page burst walks through all 256 columns of the page in sequential order, wraps at the page end and keeps running until a stop strobe arrives. For reads, a data-valid strobe is produced. It trails each address pair by the programmed latency.

Top module: `burst_col_gen`

## Requirements
- R1: After reset the mode register selects a 2-beat burst, sequential order and a read latency of 3, so that `modeIllegal` and all burst outputs are low. A mode write with `modeWrEn` high loads `modeLen` (0 = 2 beats, 1 = 4, 2 = 8, 3 = full page), `modeInterleave` (0 = sequential, 1 = interleaved) and `modeLat4` (0 = latency 3, 1 = latency 4).
- R2: A start accepted at a clock edge makes `colValid` high from that edge on. A fixed burst of L beats then shows L/2 consecutive address pairs, pair k carrying beat 2k on `colA` and beat 2k+1 on `colB`. After the last pair `colValid` falls unless a new start was taken.
- R3: In sequential order, with burst length L and start column s, beat b addresses column (s − s mod L) + ((s mod L + b) mod L).
- R4: In interleaved order, beat b addresses column (s − s mod L) + ((s mod L) XOR b).
- R5: A full-page burst produces, at beat b, column (s + b) mod 256, where s is the forced-even start. It continues across the page end until `stopEn` is seen high. The pair on display during the cycle in which `stopEn` is high is the final one.
- R6: When the mode register holds full page together with interleaved order, `modeIllegal` is high and start strobes are refused, so no burst begins.
- R7: A full-page start at an odd column raises `oddStartErr` for exactly the first pair of that burst, and the burst begins at the even column just below. Even starts and fixed-length starts leave the flag low.
- R8: `colLast` is high on the final pair of a fixed-length burst and low on every other pair. It is never high during a full-page burst.
- R9: For a read burst, `rdDataValid` is high exactly 3 clocks (latency 3) or 4 clocks (latency 4) after each cycle that shows a valid pair. Write bursts never raise it.
- R10: A start outranks both burst completion and `stopEn`. A start taken while a burst is showing its last pair, or together with `stopEn`, makes the new burst's first pair appear in the very next cycle, with no idle gap.
- R11: Burst length and order are captured at the start. A mode write during a burst changes only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| modeWrEn | input | 1 | Mode register write strobe |
| modeLen | input | 2 | Burst length code: 0=2, 1=4, 2=8, 3=full page |
| modeInterleave | input | 1 | Burst order: 0 sequential, 1 interleaved |
| modeLat4 | input | 1 | Read latency select: 0 three clocks, 1 four clocks |
| startEn | input | 1 | Begin a burst at this edge |
| startCol | input | COL_W | Starting column of the burst |
| startIsRead | input | 1 | 1 for a read burst, 0 for a write burst |
| stopEn | input | 1 | Ends the running burst after the current pair |
| colA | output | COL_W | Column of the even beat of the current pair |
| colB | output | COL_W | Column of the odd beat of the current pair |
| colValid | output | 1 | An address pair is being issued |
| colLast | output | 1 | Current pair ends a fixed-length burst |
| rdDataValid | output | 1 | Read data pair expected, delayed by the latency |
| modeIllegal | output | 1 | Mode register holds full page with interleaved order |
| oddStartErr | output | 1 | Full-page burst was started on an odd column |

## Verification
Two events can land on the same edge here. A fresh start can arrive in the cycle that shows the final pair of a fixed burst, and a start can arrive together with a stop during a full-page burst. The bench raises `startEn` while the last pair, or the stop, is on display. It then expects the new burst's first pair in the very next cycle, and it checks that the data-valid history runs on without a gap. A third case is a mode write in the middle of a burst. The running burst must keep its captured length and order, and the next burst must pick up the new setting.

// File: rtl/burst_col_pkg.sv
`timescale 1ns/1ps
package burst_col_pkg;

  // Burst length codes held in the mode register
  typedef enum logic [1:0] {
    LEN_2    = 2'd0,
    LEN_4    = 2'd1,
    LEN_8    = 2'd2,
    LEN_PAGE = 2'd3
  } burst_len_e;

  // Strobes from control to the address datapath
  typedef struct packed {
    logic loadStart;  // capture start column, clear pair counter
    logic forceEven;  // clear bit 0 of the captured start column
    logic advance;    // step to the next address pair
    logic rdBeat;     // the current pair belongs to a read burst
  } dp_strobe_t;

endpackage

// File: rtl/burst_col_ctrl.sv
`timescale 1ns/1ps
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWrEn,
  input  logic [1:0]       modeLen,
  input  logic             modeInterleave,
  input  logic             modeLat4,
  input  logic             startEn,
  input  logic             startColLsb,
  input  logic             startIsRead,
  input  logic             stopEn,
  input  logic [COL_W-2:0] pairIdx,
  output dp_strobe_t       strb,
  output logic [COL_W-1:0] burstMask,
  output logic             burstInterleave,
  output logic             lat4,
  output logic             colValid,
  output logic             colLast,
  output logic             modeIllegal,
  output logic             oddStartErr
);

  burst_len_e modeLenQ, curLenQ;
  logic modeInterQ, modeLat4Q;
  logic curInterQ, activeQ, isReadQ, oddErrQ;
  logic startOk, endNow;
  logic [COL_W-1:0] maskC;
  logic [COL_W-2:0] lastPair;

  // mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeLenQ   <= LEN_2;
      modeInterQ <= 1'b0;
      modeLat4Q  <= 1'b0;
    end else if (modeWrEn) begin
      modeLenQ   <= burst_len_e'(modeLen);
      modeInterQ <= modeInterleave;
      modeLat4Q  <= modeLat4;
    end
  end

  assign modeIllegal = (modeLenQ == LEN_PAGE) && modeInterQ;
  assign startOk     = startEn && !modeIllegal;

  // wrap mask of the running burst
  always_comb begin
    case (curLenQ)
      LEN_2:   maskC = COL_W'(1);
      LEN_4:   maskC = COL_W'(3);
      LEN_8:   maskC = COL_W'(7);
      default: maskC = '1;
    endcase
  end

  assign lastPair = maskC[COL_W-1:1];
  assign colLast  = activeQ && (curLenQ != LEN_PAGE) && (pairIdx == lastPair);
  assign endNow   = activeQ && (stopEn || colLast);

  // burst state: a start outranks completion and stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ   <= 1'b0;
      curLenQ   <= LEN_2;
      curInterQ <= 1'b0;
      isReadQ   <= 1'b0;
      oddErrQ   <= 1'b0;
    end else if (startOk) begin
      activeQ   <= 1'b1;
      curLenQ   <= modeLenQ;
      curInterQ <= modeInterQ;
      isReadQ   <= startIsRead;
      oddErrQ   <= (modeLenQ == LEN_PAGE) && startColLsb;
    end else begin
      oddErrQ <= 1'b0;
      if (endNow) activeQ <= 1'b0;
    end
  end

  always_comb begin
    strb.loadStart = startOk;
    strb.forceEven = (modeLenQ == LEN_PAGE);
    strb.advance   = activeQ;
    strb.rdBeat    = activeQ && isReadQ;
  end

  assign burstMask       = maskC;
  assign burstInterleave = curInterQ;
  assign lat4            = modeLat4Q;
  assign colValid        = activeQ;
  assign oddStartErr     = oddErrQ;

  AST_ILLEGAL_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (modeIllegal && startEn && !activeQ) |=> !activeQ); // R6
  AST_FIXED_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (colLast && !startEn) |=> !colValid); // R8
  AST_ODD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (oddStartErr && !startEn) |=> !oddStartErr); // R7

endmodule

// File: rtl/burst_col_dp.sv
`timescale 1ns/1ps
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int LAT_LO = 3,
  parameter int LAT_HI = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strb,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] burstMask,
  input  logic             burstInterleave,
  input  logic             lat4,
  output logic [COL_W-2:0] pairIdx,
  output logic [COL_W-1:0] colA,
  output logic [COL_W-1:0] colB,
  output logic             rdDataValid
);

  localparam int LANES = 2;

  logic [COL_W-1:0] startQ;
  logic [COL_W-2:0] pairQ;
  logic [LAT_HI:1]  rdPipe;
  logic [COL_W-1:0] laneCol [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= '0;
      pairQ  <= '0;
    end else if (strb.loadStart) begin
      startQ <= strb.forceEven ? {startCol[COL_W-1:1], 1'b0} : startCol;
      pairQ  <= '0;
    end else if (strb.advance) begin
      pairQ <= pairQ + 1'b1;
    end
  end

  // one address lane per strobe edge
  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    logic [COL_W-1:0] beat, offSeq, offInt, offSel;
    assign beat   = {pairQ, 1'(ln)};
    assign offSeq = startQ + beat;
    assign offInt = startQ ^ beat;
    assign offSel = burstInterleave ? offInt : offSeq;
    assign laneCol[ln] = (startQ & ~burstMask) | (offSel & burstMask);
  end

  assign colA    = laneCol[0];
  assign colB    = laneCol[1];
  assign pairIdx = pairQ;

  // read data-valid delay line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPipe <= '0;
    else       rdPipe <= {rdPipe[LAT_HI-1:1], strb.rdBeat};
  end

  assign rdDataValid = lat4 ? rdPipe[LAT_HI] : rdPipe[LAT_LO];

  AST_RD_LAT_LO: assert property (@(posedge clk) disable iff (!rstN)
    (rdDataValid && !lat4) |-> $past(strb.rdBeat, LAT_LO)); // R9
  AST_RD_LAT_HI: assert property (@(posedge clk) disable iff (!rstN)
    (rdDataValid && lat4) |-> $past(strb.rdBeat, LAT_HI)); // R9
  AST_PAGE_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadStart && strb.forceEven) |=> !colA[0]); // R7

endmodule

// File: rtl/burst_col_gen.sv
`timescale 1ns/1ps
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int LAT_LO = 3,
  parameter int LAT_HI = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWrEn,
  input  logic [1:0]       modeLen,
  input  logic             modeInterleave,
  input  logic             modeLat4,
  input  logic             startEn,
  input  logic [COL_W-1:0] startCol,
  input  logic             startIsRead,
  input  logic             stopEn,
  output logic [COL_W-1:0] colA,
  output logic [COL_W-1:0] colB,
  output logic             colValid,
  output logic             colLast,
  output logic             rdDataValid,
  output logic             modeIllegal,
  output logic             oddStartErr
);

  dp_strobe_t       strb;
  logic [COL_W-1:0] burstMask;
  logic             burstInterleave, lat4;
  logic [COL_W-2:0] pairIdx;

  burst_col_ctrl #(.COL_W(COL_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .modeWrEn(modeWrEn), .modeLen(modeLen),
    .modeInterleave(modeInterleave), .modeLat4(modeLat4),
    .startEn(startEn), .startColLsb(startCol[0]),
    .startIsRead(startIsRead), .stopEn(stopEn),
    .pairIdx(pairIdx), .strb(strb),
    .burstMask(burstMask), .burstInterleave(burstInterleave),
    .lat4(lat4), .colValid(colValid), .colLast(colLast),
    .modeIllegal(modeIllegal), .oddStartErr(oddStartErr)
  );

  burst_col_dp #(.COL_W(COL_W), .LAT_LO(LAT_LO), .LAT_HI(LAT_HI)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol),
    .burstMask(burstMask), .burstInterleave(burstInterleave),
    .lat4(lat4), .pairIdx(pairIdx),
    .colA(colA), .colB(colB), .rdDataValid(rdDataValid)
  );

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && stopEn && !startEn) |=> !colValid); // R5

endmodule

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;

  localparam int COL_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWrEn = 1'b0, modeInterleave = 1'b0, modeLat4 = 1'b0;
  logic [1:0] modeLen = 2'd0;
  logic startEn = 1'b0, startIsRead = 1'b0, stopEn = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [COL_W-1:0] colA, colB;
  logic colValid, colLast, rdDataValid, modeIllegal, oddStartErr;

  burst_col_gen #(.COL_W(COL_W)) dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeLen(modeLen),
    .modeInterleave(modeInterleave), .modeLat4(modeLat4),
    .startEn(startEn), .startCol(startCol), .startIsRead(startIsRead),
    .stopEn(stopEn), .colA(colA), .colB(colB), .colValid(colValid),
    .colLast(colLast), .rdDataValid(rdDataValid),
    .modeIllegal(modeIllegal), .oddStartErr(oddStartErr)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int curLat = 3;
  bit hist [0:7];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // column of beat b for start s and length code len (3 = full page)
  function automatic int expCol(int s, int len, int inter, int b);
    int span, base, low, off;
    span = (len == 3) ? 256 : (2 << len);
    if (len == 3) s = s - (s % 2);
    base = s - (s % span);
    low  = s % span;
    off  = inter ? (low ^ b) : ((low + b) % span);
    return base + off;
  endfunction

  task automatic observe(input bit v, input int a, input int b,
                         input bit last, input bit rd, input string req);
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v && rd;
    chk(colValid == v, req, "colValid", colValid, v);
    if (v) begin
      chk(colA == a, req, "colA", colA, a);
      chk(colB == b, req, "colB", colB, b);
      chk(colLast == last, "R8", "colLast", colLast, last);
    end
    chk(rdDataValid == hist[curLat], "R9", "rdDataValid", rdDataValid, hist[curLat]);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      observe(0, 0, 0, 0, 0, "R2");
    end
  endtask

  task automatic setMode(input int len, input int inter, input int l4);
    modeWrEn = 1'b1; modeLen = 2'(len);
    modeInterleave = 1'(inter); modeLat4 = 1'(l4);
    @(negedge clk);
    modeWrEn = 1'b0;
    curLat = l4 ? 4 : 3;
    observe(0, 0, 0, 0, 0, "R1");
  endtask

  task automatic launch(input int s, input bit rd);
    startEn = 1'b1; startCol = COL_W'(s); startIsRead = rd;
  endtask

  task automatic runFixed(input int len, input int inter, input bit rd, input int s,
                          input bit chain, input int ns, input bit nrd, input string req);
    int half;
    half = (2 << len) / 2;
    for (int k = 0; k < half; k++) begin
      @(negedge clk);
      startEn = 1'b0;
      observe(1, expCol(s, len, inter, 2*k), expCol(s, len, inter, 2*k+1),
              k == half-1, rd, req);
      chk(oddStartErr == 1'b0, "R7", "oddStartErr fixed", oddStartErr, 0);
      if (k == half-1 && chain) launch(ns, nrd);
    end
  endtask

  task automatic runPage(input int s, input bit rd, input int pairs);
    for (int k = 0; k < pairs; k++) begin
      @(negedge clk);
      startEn = 1'b0; stopEn = 1'b0;
      observe(1, expCol(s, 3, 0, 2*k), expCol(s, 3, 0, 2*k+1), 0, rd, "R5");
      chk(oddStartErr == ((k == 0) ? (s % 2) : 0), "R7", "oddStartErr",
          oddStartErr, (k == 0) ? (s % 2) : 0);
    end
  endtask

  task automatic stopNow();
    stopEn = 1'b1;
    @(negedge clk);
    stopEn = 1'b0;
    observe(0, 0, 0, 0, 0, "R5");
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) hist[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(colValid == 0, "R1", "colValid in reset", colValid, 0);
    chk(rdDataValid == 0, "R1", "rdDataValid in reset", rdDataValid, 0);
    chk(modeIllegal == 0, "R1", "modeIllegal in reset", modeIllegal, 0);
    rstN = 1'b1;
    idle(2);

    // R1: default mode is 2-beat sequential, latency 3
    launch(3, 1);
    runFixed(0, 0, 1, 3, 0, 0, 0, "R1");
    idle(6);

    // R2 R3 R4 R9: sweep of fixed lengths, orders, latencies, start columns
    for (int l4 = 0; l4 < 2; l4++) begin
      for (int len = 0; len < 3; len++) begin
        for (int inter = 0; inter < 2; inter++) begin
          setMode(len, inter, l4);
          for (int i = 0; i < 24; i++) begin
            int s;
            bit rd;
            s  = (i < 16) ? i : 232 + i;
            rd = 1'((s + len) % 2);
            launch(s, rd);
            runFixed(len, inter, rd, s, 0, 0, 0, inter ? "R4" : "R3");
            if (i % 3 == 0) idle(1);
          end
          idle(6);
        end
      end
    end

    // R10: start on the last pair gives a seamless follow-on burst
    setMode(1, 1, 0);
    launch(5, 1);
    runFixed(1, 1, 1, 5, 1, 10, 0, "R10");
    runFixed(1, 1, 0, 10, 1, 13, 1, "R10");
    runFixed(1, 1, 1, 13, 0, 0, 0, "R10");
    idle(6);

    // R11: a mode write during a burst does not alter it
    setMode(2, 0, 1);
    launch(6, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      startEn = 1'b0; modeWrEn = 1'b0;
      observe(1, expCol(6, 2, 0, 2*k), expCol(6, 2, 0, 2*k+1), k == 3, 1, "R11");
      if (k == 0) begin
        modeWrEn = 1'b1; modeLen = 2'd0; modeInterleave = 1'b1; modeLat4 = 1'b1;
      end
    end
    idle(6);
    launch(6, 0);
    runFixed(0, 1, 0, 6, 0, 0, 0, "R11");
    idle(2);

    // R6: full page with interleaved order is illegal and refuses starts
    setMode(3, 1, 0);
    chk(modeIllegal == 1, "R6", "modeIllegal", modeIllegal, 1);
    launch(4, 0);
    @(negedge clk);
    startEn = 1'b0;
    observe(0, 0, 0, 0, 0, "R6");
    idle(2);
    setMode(3, 0, 0);
    chk(modeIllegal == 0, "R6", "modeIllegal cleared", modeIllegal, 0);

    // R5: full page wraps across the page end until stopped
    launch(250, 1);
    runPage(250, 1, 130);
    stopNow();
    idle(6);

    // R7: odd full-page start is flagged and forced even
    launch(5, 0);
    runPage(5, 0, 3);
    stopNow();
    idle(2);

    // R10: start together with stop restarts at once
    launch(7, 0);
    runPage(7, 0, 4);
    stopEn = 1'b1;
    launch(100, 1);
    runPage(100, 1, 2);
    stopNow();
    idle(6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule